// File: doc/BRIEF.md
# Idle-Trained Serial Stream Descrambler

This block takes a scrambled NRZ receive stream, one bit per accepted clock, and recovers the plain bit stream. It rebuilds the scrambling key locally with an 11-stage shift-register generator, using the recurrence x^11 + x^9 + 1, and XORs each received bit with the matching key bit. The transmitter scrambles with the same relation, so the XOR undoes it.

The key generator is trained without any side information. While it is acquiring, the block assumes the line carries scrambled idle, which is all ones before scrambling. Under that assumption each received bit, inverted, is the key bit, so the inverted received bits are shifted into the generator. Once the descrambled output has shown twelve 5-bit idle groups in a row, the generator free-runs and the block reports lock.

After lock, a line monitor watches for runs of descrambled ones. A hold timer, counted in accepted bits, must see such a run before it expires, or the block drops lock, clears the generator and starts acquisition again. The output is unaligned: no code-group boundary is implied. A bypass control passes the input straight through and forces the locked flag high.

Top module: `idle_descrambler`

## Requirements
- R1: For every accepted bit (in_valid high), out_bit on the next cycle equals in_bit XOR k, where k is the XOR of the key-stream bits produced 11 and 9 accepted bits earlier (key history is all zero after reset). out_bit holds its value on cycles with no accepted bit.
- R2: out_valid equals in_valid delayed by one clock. Cycles with in_valid low do not change the key history, the run count, the timer or the lock state.
- R3: While unlocked, the key-stream bit produced for each accepted bit is the inverse of in_bit. From a cleared history, lock is gained after no fewer than 60 and no more than 71 accepted scrambled idle bits.
- R4: While unlocked, lock is declared (locked rises on the next cycle) on the accepted bit that completes 60 consecutive descrambled ones (LOCK_GROUPS=12 groups of GROUP_BITS=5). That bit loads the hold timer with HOLD_BITS.
- R5: While locked, the key-stream bit produced is the generator's own key bit k, so arbitrary plain data is recovered bit-exactly.
- R6: While locked, the accepted bit that completes IDLE_RUN_BITS=58 consecutive descrambled ones reloads the hold timer and restarts the run count. A run of 57 ones followed by a zero reloads nothing.
- R7: While locked, the timer drops by one on each accepted bit that does not reload it. The HOLD_BITS-th such bit after a load clears lock, the key history and the run count. After HOLD_BITS-1 such bits the block is still locked.
- R8: With bypass high, out_bit on the cycle after an accepted bit equals that in_bit, and locked reads 1. Bypass does not alter the key history, run count, timer or lock state, which keep evolving as with bypass low.
- R9: During and right after reset, out_valid, out_bit and locked are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe marking in_bit as an accepted bit |
| in_bit | input | 1 | Scrambled NRZ receive bit |
| bypass | input | 1 | Pass input through unchanged and force locked high |
| out_valid | output | 1 | Registered copy of in_valid |
| out_bit | output | 1 | Descrambled (or bypassed) bit |
| locked | output | 1 | Key generator is synchronised, or bypass is high |

## Verification
The bench drives an independent scrambler and compares every output against a behavioural model on every clock. Each corner it targets exposes a specific kind of fault.

- **Lock threshold.** It approaches the threshold exactly: a design counting 59 or 61 ones moves the locked edge by a cycle.
- **Near-miss idle runs.** It sends runs of 57 ones broken by a zero, which must not keep lock alive. A monitor that counted total ones instead of a run would hold lock and never drop.
- **Hold-timer boundary.** It checks the HOLD_BITS-1 and HOLD_BITS bit points, where an off-by-one timer drops lock early or late.
- **Idle gaps and bypass.** It interleaves cycles with no valid bit and toggles bypass. A design that advances state on idle cycles, or trains on bypassed data differently, then loses bit-exactness in the descrambled output.

// File: rtl/dscr_pkg.sv
package dscr_pkg;

  localparam int KEY_LEN = 11;
  localparam int KEY_TAP = 9;

  typedef logic [KEY_LEN-1:0] key_t;

  typedef enum logic {
    ST_ACQ   = 1'b0,
    ST_TRACK = 1'b1
  } sync_st_t;

  // key bit predicted for the next accepted bit: taps 11 and 9 back
  function automatic logic key_bit(key_t s);
    return s[KEY_LEN-1] ^ s[KEY_TAP-1];
  endfunction

  // append the newest key-stream bit at position 0
  function automatic key_t key_shift(key_t s, logic b);
    return {s[KEY_LEN-2:0], b};
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dscr_keygen.sv
module dscr_keygen
  import dscr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic clear,
  input  logic track,
  input  logic rx_bit,
  output key_t state,
  output logic key
);

  logic fresh;

  assign key   = key_bit(state);
  // in acquisition the line is assumed idle: key = inverted received bit
  assign fresh = track ? key : ~rx_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= '0;
    end else if (adv) begin
      if (clear) state <= '0;
      else       state <= key_shift(state, fresh);
    end
  end

endmodule

// File: rtl/dscr_run_mon.sv
module dscr_run_mon #(
  parameter int unsigned ACQ_BITS = 60,
  parameter int unsigned TRK_BITS = 58
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic plain_bit,
  input  logic track,
  input  logic clear,
  output logic hit
);

  localparam int unsigned MAX_BITS = dscr_pkg::max_u(ACQ_BITS, TRK_BITS);
  localparam int unsigned RW       = $clog2(MAX_BITS + 1);

  logic [RW-1:0] run;
  logic [RW-1:0] thr_m1;

  assign thr_m1 = track ? RW'(TRK_BITS - 1) : RW'(ACQ_BITS - 1);
  assign hit    = adv && plain_bit && (run == thr_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0;
    end else if (adv) begin
      if (hit || clear)   run <= '0;
      else if (plain_bit) run <= run + RW'(1);
      else                run <= '0;
    end
  end

endmodule

// File: rtl/dscr_hold_ctl.sv
module dscr_hold_ctl
  import dscr_pkg::*;
#(
  parameter int unsigned HOLD_BITS = 90250,
  localparam int unsigned TW = $clog2(HOLD_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          hit,
  output logic          track,
  output logic [TW-1:0] timer,
  output logic          acq_evt,
  output logic          reload_evt,
  output logic          expire_evt
);

  sync_st_t st;

  assign track      = (st == ST_TRACK);
  assign acq_evt    = adv && hit && !track;
  assign reload_evt = adv && hit && track;
  assign expire_evt = adv && !hit && track && (timer == TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_ACQ;
      timer <= '0;
    end else if (acq_evt || reload_evt) begin
      st    <= ST_TRACK;
      timer <= TW'(HOLD_BITS);
    end else if (expire_evt) begin
      st    <= ST_ACQ;
      timer <= '0;
    end else if (adv && track) begin
      timer <= timer - TW'(1);
    end
  end

endmodule

// File: rtl/idle_descrambler.sv
module idle_descrambler
  import dscr_pkg::*;
#(
  parameter int unsigned HOLD_BITS     = 90250,
  parameter int unsigned GROUP_BITS    = 5,
  parameter int unsigned LOCK_GROUPS   = 12,
  parameter int unsigned IDLE_RUN_BITS = 58
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  input  logic bypass,
  output logic out_valid,
  output logic out_bit,
  output logic locked
);

  localparam int unsigned ACQ_BITS = GROUP_BITS * LOCK_GROUPS;
  localparam int unsigned TW       = $clog2(HOLD_BITS + 1);

  key_t          key_state;
  logic          key;
  logic          plain;
  logic          track;
  logic          run_hit;
  logic [TW-1:0] hold_timer;
  logic          acq_evt;
  logic          reload_evt;
  logic          expire_evt;

  assign plain = in_bit ^ key;

  dscr_keygen u_keygen (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (in_valid),
    .clear  (expire_evt),
    .track  (track),
    .rx_bit (in_bit),
    .state  (key_state),
    .key    (key)
  );

  dscr_run_mon #(
    .ACQ_BITS (ACQ_BITS),
    .TRK_BITS (IDLE_RUN_BITS)
  ) u_run_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (in_valid),
    .plain_bit (plain),
    .track     (track),
    .clear     (expire_evt),
    .hit       (run_hit)
  );

  dscr_hold_ctl #(
    .HOLD_BITS (HOLD_BITS)
  ) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (in_valid),
    .hit        (run_hit),
    .track      (track),
    .timer      (hold_timer),
    .acq_evt    (acq_evt),
    .reload_evt (reload_evt),
    .expire_evt (expire_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_bit <= bypass ? in_bit : plain;
    end
  end

  assign locked = bypass | track;

endmodule

// File: rtl/idle_descrambler_chk.sv
module idle_descrambler_chk
  import dscr_pkg::*;
#(
  parameter int unsigned HOLD_BITS = 90250,
  localparam int unsigned TW = $clog2(HOLD_BITS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_bit,
  input logic          bypass,
  input logic          out_valid,
  input logic          out_bit,
  input logic          track,
  input key_t          key_state,
  input logic [TW-1:0] hold_timer,
  input logic          acq_evt,
  input logic          reload_evt,
  input logic          expire_evt
);

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_bit) && $stable(key_state) && $stable(hold_timer));

  p_lock_loads_timer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acq_evt |=> track && hold_timer == TW'(HOLD_BITS));

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> track && hold_timer == TW'(HOLD_BITS));

  p_expire_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> !track && key_state == '0);

  p_countdown_r7: assert property (@(posedge clk) disable iff (!rst_n)
    track && in_valid && !reload_evt && !expire_evt |=> hold_timer == $past(hold_timer) - TW'(1));

  p_bypass_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && bypass |=> out_bit == $past(in_bit));

  p_events_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acq_evt, reload_evt, expire_evt}));

endmodule

bind idle_descrambler idle_descrambler_chk #(.HOLD_BITS(HOLD_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_bit     (in_bit),
  .bypass     (bypass),
  .out_valid  (out_valid),
  .out_bit    (out_bit),
  .track      (track),
  .key_state  (key_state),
  .hold_timer (hold_timer),
  .acq_evt    (acq_evt),
  .reload_evt (reload_evt),
  .expire_evt (expire_evt)
);

// File: tb/test_idle_descrambler.sv
`timescale 1ns/1ps
module test_idle_descrambler;

  localparam int HOLD = 200;
  localparam int LOCK_RUN = 60;
  localparam int IDLE_RUN = 58;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic bypass = 1'b0;
  logic out_valid, out_bit, locked;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit cmp_en = 0;

  // bench-side scrambler key history, oldest first
  bit tq[$] = '{1, 0, 1, 1, 0, 0, 1, 1, 1, 0, 1};
  // reference model state
  bit mk[$] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
  bit m_valid = 0, m_bit = 0, m_lock = 0;
  int m_run = 0, m_tmr = 0;
  bit last_in = 0;

  idle_descrambler #(.HOLD_BITS(HOLD)) i_idle_descrambler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .bypass(bypass), .out_valid(out_valid), .out_bit(out_bit), .locked(locked)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_valid = 0; m_bit = 0; m_lock = 0; m_run = 0; m_tmr = 0;
      foreach (mk[i]) mk[i] = 0;
    end else begin
      m_valid = in_valid;
      if (in_valid) begin
        bit k, d, hit, ex;
        int need;
        k = mk[0] ^ mk[2];
        d = in_bit ^ k;
        m_bit = bypass ? in_bit : d;
        need = m_lock ? IDLE_RUN : LOCK_RUN;
        hit = d && (m_run == need - 1);
        ex = m_lock && !hit && (m_tmr == 1);
        if (ex) begin
          foreach (mk[i]) mk[i] = 0;
        end else begin
          mk.push_back(m_lock ? k : !in_bit);
          void'(mk.pop_front());
        end
        if (hit || ex) m_run = 0;
        else m_run = d ? m_run + 1 : 0;
        if (!m_lock) begin
          if (hit) begin m_lock = 1; m_tmr = HOLD; end
        end else if (hit) m_tmr = HOLD;
        else if (m_tmr == 1) m_lock = 0;
        else m_tmr--;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R2 out_valid", out_valid, m_valid);
      chk("R1 R5 out_bit", out_bit, m_bit);
      chk("R4 R7 locked", locked, bypass | m_lock);
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic send(input bit plain);
    bit txk;
    @(posedge clk); #2;
    txk = tq[0] ^ tq[2];
    tq.push_back(txk);
    void'(tq.pop_front());
    in_bit = plain ^ txk;
    last_in = in_bit;
    in_valid = 1'b1;
  endtask

  task automatic gap();
    @(posedge clk); #2;
    in_valid = 1'b0;
    in_bit = 1'($urandom % 2);
  endtask

  task automatic settle();
    @(posedge clk); #2;
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle_until_lock(output int n);
    n = 0;
    forever begin
      bit txk;
      @(posedge clk); #2;
      if (m_lock || n > 200) begin in_valid = 1'b0; break; end
      txk = tq[0] ^ tq[2];
      tq.push_back(txk);
      void'(tq.pop_front());
      in_bit = 1'b1 ^ txk;
      in_valid = 1'b1;
      n++;
    end
  endtask

  initial begin
    int n;
    // R9: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 out_valid", out_valid, 1'b0);
    chk("R9 out_bit", out_bit, 1'b0);
    chk("R9 locked", locked, 1'b0);
    @(posedge clk); #2 rst_n = 1'b1;
    cmp_en = 1;
    @(negedge clk);
    chk("R9 locked after release", locked, 1'b0);

    // R3 R4: first acquisition from cleared history
    idle_until_lock(n);
    @(negedge clk);
    chk("R3 lock gained within 60..71 bits", (n >= LOCK_RUN && n <= LOCK_RUN + 11), 1'b1);
    chk("R4 locked after idle", locked, 1'b1);

    // R5 R6: data bursts separated by idle keep lock
    for (int b = 0; b < 8; b++) begin
      for (int i = 0; i < 62; i++) begin
        if (i % 9 == 4) gap();
        send(1'b1);
      end
      for (int i = 0; i < 90; i++) send(1'($urandom % 2));
    end
    settle();
    chk("R6 lock kept by idle runs", locked, 1'b1);

    // R6 R7: runs of 57 ones never reload, lock expires
    for (int r = 0; r < 5; r++) begin
      for (int i = 0; i < IDLE_RUN - 1; i++) send(1'b1);
      send(1'b0);
    end
    settle();
    chk("R6 R7 57-bit runs let lock lapse", locked, 1'b0);

    // R3: reacquire after lock loss, with gaps (R2)
    idle_until_lock(n);
    @(negedge clk);
    chk("R3 relock bit count", (n >= LOCK_RUN && n <= LOCK_RUN + 11), 1'b1);

    // R7: exact hold boundary from a fresh lock
    for (int i = 0; i < HOLD - 1; i++) send(1'(i % 2));
    settle();
    chk("R7 still locked at HOLD-1", locked, 1'b1);
    send(1'b0);
    settle();
    chk("R7 lock lost at HOLD", locked, 1'b0);

    // R8: bypass while unlocked
    bypass = 1'b1;
    for (int i = 0; i < 30; i++) send(1'($urandom % 2));
    settle();
    chk("R8 out_bit equals input", out_bit, last_in);
    chk("R8 locked forced", locked, 1'b1);
    bypass = 1'b0;
    @(negedge clk);
    chk("R8 true lock state after bypass", locked, 1'b0);

    // R2 R5: acquisition through gaps, then random data
    for (int i = 0; i < 150; i++) begin
      if (i % 7 == 3) gap();
      send(1'b1);
    end
    for (int i = 0; i < 100; i++) send(1'($urandom % 2));
    settle();
    chk("R5 locked through data", locked, 1'b1);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule